// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master that lets software read and write the registers of external Ethernet PHYs over the two-wire MDC/MDIO serial interface, using standard Clause 22 framing. Software sees an 8-bit register bus with eight locations. Four of them hold a 32-bit command word, with the least significant byte at the lowest location. The other four hold a 32-bit result word in the same byte order.

Software loads the data, PHY address and register address bytes first. It then writes the top byte with its start flag set. The controller derives a slow management clock from the system clock and shifts the frame out. It releases the data line while a PHY answers a read, and clears the start flag once the last bit has gone. A read leaves either the 16-bit answer or a failure indication in the result word. Polling the top command byte tells software when the controller is free again.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Locations 0 to 3 hold command bits 7:0, 15:8, 23:16 and 31:24 respectively. While idle, a write stores the byte, and reading any of the four returns the stored byte.
- R2: Locations 4 to 7 return result bits 7:0, 15:8, 23:16 and 31:24. Writes to them have no effect on what they return.
- R3: Writing location 3 with bit 7 (command bit 31, the busy flag) set while idle starts a frame. Bit 31 then reads 1 until the frame ends and reads 0 afterwards. The other command bits keep their values.
- R4: While the busy flag is 1, writes to locations 0 to 3 are ignored.
- R5: The command fields are: bit 26 = 1 for a write and 0 for a read; bits 25:21 = PHY address; bits 20:16 = register address; bits 15:0 = write data. A write frame is, MSB first: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10, then 16 data bits. The output enable is held high for all 64 bits.
- R6: A read frame sends 32 ones, 01, opcode 10, PHY address and register address with the output enable high. The enable is low for the last 18 bit times (turnaround and data).
- R7: After a successful read, result bits 15:0 hold the 16 bits sampled from the PHY, MSB first, and bit 31 is 0. A write frame leaves the result word unchanged.
- R8: If the second turnaround bit sampled during a read is 1 (no PHY answering), result bit 31 is 1 and bits 15:0 are 0xFFFF.
- R9: MDC is low while idle. Each MDC phase lasts ceil(SYS_CLK_HZ / (2 * MDC_MAX_HZ)) system cycles, and a frame has exactly 64 MDC rising edges.
- R10: MDIO output changes only while MDC is low, in the cycle MDC falls. Input bits are sampled in the cycle MDC rises.
- R11: After reset, all eight locations read 0, and MDC and the output enable are low. The output enable stays low whenever the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register location (0-3 command, 4-7 result) |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Byte at reg_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
A bit counter in the wrong state appears on the pins within one MDC period. It shows up as a frame that does not have 64 rising edges, or as a shifted capture of the opcode and address fields. A wrong output-enable decode shows within the same frame as the enable driving during the turnaround. A stale turnaround sample or receive shift register is seen at the next result-word read as a wrong failure flag or a shifted value. The sweep covers every PHY address in both directions, including addresses where no PHY answers.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN  = 64;
  localparam int PRE_LEN    = 32;
  localparam int TA_HI_IDX  = 46;  // first turnaround bit
  localparam int TA_LO_IDX  = 47;  // second turnaround bit, 0 when a PHY answers
  localparam int DATA_IDX   = 48;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int GO_BIT     = 31;
  localparam int WR_BIT     = 26;
  localparam int FAIL_BIT   = 31;
  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] TA_DRIVE   = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap      = run && (cnt_q == CW'(HALF - 1));
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        ld_write,
  input  logic [4:0]  ld_phy,
  input  logic [4:0]  ld_reg,
  input  logic [15:0] ld_data,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        op_write,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output logic        rd_fail
);
  logic [FRAME_LEN-1:0] tx_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 wr_q;
  logic [15:0]          rx_q;
  logic                 ta_bad_q;
  logic                 last_bit;

  assign last_bit = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign done     = active && fall_tick && last_bit;
  assign op_write = wr_q;
  assign mdio_o   = active ? tx_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe  = active && (wr_q || (idx_q < IDX_W'(TA_HI_IDX)));
  assign rd_data  = rx_q;
  assign rd_fail  = ta_bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      tx_q     <= '1;
      idx_q    <= '0;
      wr_q     <= 1'b0;
      rx_q     <= '0;
      ta_bad_q <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      idx_q  <= '0;
      wr_q   <= ld_write;
      tx_q   <= {{PRE_LEN{1'b1}}, START_CODE, (ld_write ? OP_WRITE : OP_READ),
                 ld_phy, ld_reg, (ld_write ? TA_DRIVE : 2'b11),
                 (ld_write ? ld_data : 16'hFFFF)};
    end else if (active) begin
      if (rise_tick) begin
        if (idx_q == IDX_W'(TA_LO_IDX)) ta_bad_q <= mdio_i;
        if (idx_q >= IDX_W'(DATA_IDX))  rx_q <= {rx_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        tx_q <= {tx_q[FRAME_LEN-2:0], 1'b1};
        if (last_bit) active <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        done,
  input  logic        done_write,
  input  logic [15:0] rd_data,
  input  logic        rd_fail,
  output logic        start,
  output logic        ld_write,
  output logic [4:0]  ld_phy,
  output logic [4:0]  ld_reg,
  output logic [15:0] ld_data
);
  logic [31:0] cmd_q;
  logic [31:0] sts_q;
  logic        busy;

  assign busy     = cmd_q[GO_BIT];
  assign start    = wr && !busy && (addr == 3'd3) && wdata[7];
  // fields of the launching command: top byte comes from the bus this cycle
  assign ld_write = wdata[WR_BIT-24];
  assign ld_phy   = {wdata[1:0], cmd_q[23:21]};
  assign ld_reg   = cmd_q[20:16];
  assign ld_data  = cmd_q[15:0];

  assign rdata = addr[2] ? sts_q[8*addr[1:0] +: 8] : cmd_q[8*addr[1:0] +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
      sts_q <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (wr && !busy && !addr[2] && (addr[1:0] == 2'(b)))
          cmd_q[8*b +: 8] <= wdata;
      end
      if (done) begin
        cmd_q[GO_BIT] <= 1'b0;
        if (!done_write)
          sts_q <= rd_fail ? {1'b1, 15'b0, 16'hFFFF} : {16'b0, rd_data};
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  input  logic       mdio_i
);
  localparam int HALF = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  logic        start, ld_write, active, done, op_write, rd_fail;
  logic        rise_tick, fall_tick;
  logic [4:0]  ld_phy, ld_reg;
  logic [15:0] ld_data, rd_data;

  mdio_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done(done), .done_write(op_write), .rd_data(rd_data),
    .rd_fail(rd_fail), .start(start), .ld_write(ld_write), .ld_phy(ld_phy),
    .ld_reg(ld_reg), .ld_data(ld_data)
  );

  mdio_clk_div #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_write(ld_write),
    .ld_phy(ld_phy), .ld_reg(ld_reg), .ld_data(ld_data),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .active(active), .done(done), .op_write(op_write), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_data(rd_data), .rd_fail(rd_fail)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [31:0] cmd_q
);
  // R9: management clock parked low while no frame is pending
  a_r9_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[31] |-> !mdc);

  // R11: pad released whenever idle
  a_r11_oe_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_q[31] |-> !mdio_oe);

  // R4: command contents frozen during a frame
  a_r4_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[31] && $past(cmd_q[31])) |-> $stable(cmd_q[30:0]));

  // R10: data out stays put while the clock is high
  a_r10_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R3: busy flag drops together with the final clock fall
  a_r3_go_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[31]) |-> $fell(mdc));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .cmd_q(u_regs.cmd_q)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SYS_HZ     = 10_000_000;
  localparam int MDC_HZ     = 2_500_000;
  localparam int HALF       = (SYS_HZ + 2 * MDC_HZ - 1) / (2 * MDC_HZ);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       mdc, mdio_o, mdio_oe;
  logic       mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;
  int high_cnt = 0;
  int base_r = 0;
  int r10_viol = 0;
  logic [63:0] cap = '0;
  logic        cur_present = 1'b1;
  logic [15:0] cur_data = '0;
  logic        mdc_prev = 1'b0, o_prev = 1'b1;

  mdio_mgmt_master #(.SYS_CLK_HZ(SYS_HZ), .MDC_MAX_HZ(MDC_HZ)) u_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: bit index = rising edges since the frame began
  function automatic logic phy_bit(input int idx);
    if (idx == 47) return !cur_present;
    if (idx >= 48 && idx <= 63) return cur_present ? cur_data[63 - idx] : 1'b1;
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    cap      <= {cap[62:0], (mdio_oe ? mdio_o : 1'b0)};
    rise_cnt <= rise_cnt + 1;
  end
  always @(negedge mdc) mdio_i <= phy_bit(rise_cnt - base_r);

  always @(negedge clk) begin
    if (mdc) high_cnt <= high_cnt + 1;
    if (rst_n && mdc && mdc_prev && (mdio_o !== o_prev)) r10_viol <= r10_viol + 1;
    mdc_prev <= mdc;
    o_prev   <= mdio_o;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_word(input logic hi, output logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      reg_addr = {hi, 2'(b)};
      #1 w[8*b +: 8] = reg_rdata;
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    for (int b = 0; b < 4; b++) bus_write(3'(b), w[8*b +: 8]);
  endtask

  task automatic wait_idle(output logic ok);
    ok = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      reg_addr = 3'd3;
      #1 if (!reg_rdata[7]) begin ok = 1'b1; break; end
    end
  endtask

  // issue one frame; poke=1 hammers the command bytes while busy
  task automatic run_frame(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] d, input logic present, input logic poke,
                           output logic [31:0] word);
    logic ok;
    int   h0;
    word        = {1'b1, 4'b0, wr, phy, rg, d};
    cur_present = present;
    cur_data    = d;
    base_r      = rise_cnt;
    h0          = high_cnt;
    write_word(word);
    @(negedge clk); reg_addr = 3'd3;
    #1 check("R3 busy after start", {63'b0, reg_rdata[7]}, 64'd1);
    if (poke) for (int b = 0; b < 4; b++) bus_write(3'(b), 8'h5A ^ 8'(b));
    wait_idle(ok);
    check("R3 busy clears", {63'b0, ok}, 64'd1);
    @(negedge clk);
    check("R9 rising edges per frame", 64'(rise_cnt - base_r), 64'd64);
    check("R9 high time per frame", 64'(high_cnt - h0), 64'(64 * HALF));
    check("R9 mdc idle low", {63'b0, mdc}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w, word, sts_exp;
    logic [4:0]  rg;
    logic [15:0] d;
    logic        pres;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    read_word(1'b0, w); check("R11 command after reset", 64'(w), 64'd0);
    read_word(1'b1, w); check("R11 result after reset", 64'(w), 64'd0);
    check("R11 mdc/oe after reset", {62'b0, mdc, mdio_oe}, 64'd0);

    // R1 byte map, several patterns with the start flag clear
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = (32'h1357_9BDF * 32'(p + 1)) & 32'h7FFF_FFFF;
      write_word(pat);
      read_word(1'b0, w);
      check("R1 command byte readback", 64'(w), 64'(pat));
    end
    // R2 result locations ignore writes
    for (int b = 4; b < 8; b++) bus_write(3'(b), 8'hFF);
    read_word(1'b1, w); check("R2 result unchanged by writes", 64'(w), 64'd0);
    check("R11 idle oe low", {63'b0, mdio_oe}, 64'd0);

    // R4 writes during a frame are dropped
    run_frame(1'b1, 5'd9, 5'd4, 16'hBEEF, 1'b1, 1'b1, word);
    read_word(1'b0, w);
    check("R4 command unchanged by busy writes", 64'(w), 64'(word & 32'h7FFF_FFFF));
    sts_exp = 32'd0;

    // sweep all PHY addresses: a write then a read
    for (int p = 0; p < 32; p++) begin
      rg = 5'(31 - p);
      d  = 16'(p * 2097) ^ 16'h5AC3;
      run_frame(1'b1, 5'(p), rg, d, 1'b1, 1'b0, word);
      check("R5 write frame bits", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'(p), rg, 2'b10, d});
      read_word(1'b0, w);
      check("R3 command keeps fields", 64'(w), 64'(word & 32'h7FFF_FFFF));
      read_word(1'b1, w);
      check("R7 write leaves result", 64'(w), 64'(sts_exp));

      rg   = 5'(p) ^ 5'h0A;
      d    = {5'(p), rg, 3'(p), 3'b101};
      pres = (p % 5) != 3;
      run_frame(1'b0, 5'(p), rg, d, pres, 1'b0, word);
      check("R6 read frame header and release", cap,
            {32'hFFFF_FFFF, 2'b01, 2'b10, 5'(p), rg, 18'b0});
      sts_exp = pres ? {16'b0, d} : {1'b1, 15'b0, 16'hFFFF};
      read_word(1'b1, w);
      if (pres) check("R7 read data", 64'(w), 64'(sts_exp));
      else      check("R8 absent phy", 64'(w), 64'(sts_exp));
    end

    check("R10 mdio changes only while mdc low", 64'(r10_viol), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule